// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital front end of a serial-input, voltage-output converter. A host writes a command word over three wires: an active-low frame line, a serial clock and a data line. Bits are taken on every falling clock edge, most significant bit first. A full frame carries a few leading bits that are ignored, a two-bit power-mode field and the converter code. On the falling edge that delivers the final bit, the code register and the mode register both update in that edge. They do not wait for the frame line to rise.

The mode register drives four termination controls for the output stage. One enables the output amplifier. Two tie the output to ground through a low or a high resistance. The fourth floats the output. A frame that the host cuts short by raising the frame line changes nothing. Clock edges that arrive after a completed frame are ignored until the frame line has gone high and then low again. Parameters select the frame length and the code width. The default is a 24-bit frame with a 16-bit code. The short variant is a 16-bit frame with a 14-bit code.

Top module: `dac_cmd_rx`

## Requirements
- R1: While `rst_n` is low, and without any clock edge, `dac_code` is zero and `pwr_mode` is 2'b00. A frame in progress when reset is applied is dropped.
- R2: On the falling `sclk` edge that carries frame bit FRAME_BITS-1, `dac_code` takes the last CODE_BITS bits of the frame, first bit received as the MSB.
- R3: `pwr_mode` takes the two bits received just before the code field, earlier bit as bit 1, in the same edge as `dac_code`.
- R4: Exactly one termination control is high. The mapping is 2'b00 to `amp_en`, 2'b01 to `term_1k`, 2'b10 to `term_100k` and 2'b11 to `out_hiz`.
- R5: The update happens while `frame_n` is still low. Edges 1 to FRAME_BITS-1 of a frame change neither output.
- R6: If `frame_n` goes high before the final edge, the partial frame leaves both registers unchanged. Clock edges while `frame_n` is high change nothing.
- R7: After a frame completes, further falling edges with `frame_n` held low change nothing. A new frame begins only after `frame_n` goes high and then low.
- R8: The FRAME_BITS-CODE_BITS-2 leading bits of a frame have no effect on any output.
- R9: With FRAME_BITS=16 and CODE_BITS=14, the frame executes on the 16th falling edge, with the mode field in the first two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data taken on falling edges |
| frame_n | input | 1 | Active-low frame line; high clears frame progress |
| sdat | input | 1 | Serial data, MSB first |
| dac_code | output | CODE_BITS | Converter code register |
| pwr_mode | output | 2 | Operating mode register |
| amp_en | output | 1 | Output amplifier enabled (normal mode) |
| term_1k | output | 1 | Output tied to ground through low resistance |
| term_100k | output | 1 | Output tied to ground through high resistance |
| out_hiz | output | 1 | Output floated |

## Verification
Three events can fall in the same falling edge: completing the frame, loading the code, and changing the mode. The frame line may also rise in the half period either side of that edge. The bench samples just before the final edge, expecting the old values. It samples again just after, with `frame_n` still low, and expects the new code, the new mode and the new termination state together. It also raises `frame_n` at every earlier bit position, including one bit short of the end, and expects the registers untouched. After a completed frame it keeps clocking with `frame_n` held low and expects nothing to move.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE   = 2'b00,
        PM_GND_LOW  = 2'b01,
        PM_GND_HIGH = 2'b10,
        PM_FLOAT    = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        logic amp_en;
        logic term_1k;
        logic term_100k;
        logic out_hiz;
    } term_ctl_t;

    localparam int MODE_BITS = 2;

endpackage

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter #(
    parameter int FRAME_BITS = 24,
    parameter int KEEP_BITS  = 18,
    localparam int CNT_W     = $clog2(FRAME_BITS)
) (
    input  logic                 rst_n,
    input  logic                 sclk,
    input  logic                 frame_n,
    input  logic                 sdat,
    output logic [KEEP_BITS-1:0] word_o,
    output logic                 last_o,
    output logic                 done_o
);

    typedef struct packed {
        logic [KEEP_BITS-2:0] sr;
        logic [CNT_W-1:0]     cnt;
        logic                 done;
    } shift_t;

    shift_t s_d, s_q;
    logic   frame_clr;
    logic   at_last;

    assign frame_clr = frame_n | ~rst_n;
    assign at_last   = (s_q.cnt == CNT_W'(FRAME_BITS - 1));

    always_comb begin
        s_d = s_q;
        if (!s_q.done) begin
            s_d.sr = {s_q.sr[KEEP_BITS-3:0], sdat};
            if (at_last) begin
                s_d.cnt  = '0;
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(negedge sclk or posedge frame_clr) begin
        if (frame_clr) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_o = {s_q.sr, sdat};
    assign last_o = !s_q.done && at_last;
    assign done_o = s_q.done;

endmodule

// File: rtl/dac_field_split.sv
module dac_field_split
    import dac_rx_pkg::*;
#(
    parameter int CODE_BITS = 16,
    localparam int KEEP_BITS = CODE_BITS + MODE_BITS
) (
    input  logic [KEEP_BITS-1:0] word_i,
    output logic [CODE_BITS-1:0] code_o,
    output pwr_mode_e            mode_o
);

    assign code_o = word_i[CODE_BITS-1:0];
    assign mode_o = pwr_mode_e'(word_i[KEEP_BITS-1:CODE_BITS]);

endmodule

// File: rtl/dac_out_hold.sv
module dac_out_hold
    import dac_rx_pkg::*;
#(
    parameter int CODE_BITS = 16
) (
    input  logic                 rst_n,
    input  logic                 sclk,
    input  logic                 load_i,
    input  logic [CODE_BITS-1:0] code_i,
    input  pwr_mode_e            mode_i,
    output logic [CODE_BITS-1:0] code_o,
    output pwr_mode_e            mode_o
);

    typedef struct packed {
        logic [CODE_BITS-1:0] code;
        pwr_mode_e            mode;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (load_i) begin
            h_d.code = code_i;
            h_d.mode = mode_i;
        end
    end

    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign code_o = h_q.code;
    assign mode_o = h_q.mode;

endmodule

// File: rtl/dac_term_decode.sv
module dac_term_decode
    import dac_rx_pkg::*;
(
    input  pwr_mode_e mode_i,
    output term_ctl_t ctl_o
);

    always_comb begin
        ctl_o = '0;
        unique case (mode_i)
            PM_ACTIVE:   ctl_o.amp_en    = 1'b1;
            PM_GND_LOW:  ctl_o.term_1k   = 1'b1;
            PM_GND_HIGH: ctl_o.term_100k = 1'b1;
            PM_FLOAT:    ctl_o.out_hiz   = 1'b1;
            default:     ctl_o.out_hiz   = 1'b1;
        endcase
    end

endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx
    import dac_rx_pkg::*;
#(
    parameter int FRAME_BITS = 24,
    parameter int CODE_BITS  = 16
) (
    input  logic                 rst_n,
    input  logic                 sclk,
    input  logic                 frame_n,
    input  logic                 sdat,
    output logic [CODE_BITS-1:0] dac_code,
    output logic [1:0]           pwr_mode,
    output logic                 amp_en,
    output logic                 term_1k,
    output logic                 term_100k,
    output logic                 out_hiz
);

    localparam int KEEP_BITS = CODE_BITS + MODE_BITS;

    logic [KEEP_BITS-1:0] rx_word;
    logic                 frame_last;
    logic                 frame_done;
    logic                 load;
    logic [CODE_BITS-1:0] fld_code;
    pwr_mode_e            fld_mode;
    pwr_mode_e            mode_q;
    term_ctl_t            term;

    dac_frame_shifter #(
        .FRAME_BITS (FRAME_BITS),
        .KEEP_BITS  (KEEP_BITS)
    ) u_shift (
        .rst_n   (rst_n),
        .sclk    (sclk),
        .frame_n (frame_n),
        .sdat    (sdat),
        .word_o  (rx_word),
        .last_o  (frame_last),
        .done_o  (frame_done)
    );

    dac_field_split #(
        .CODE_BITS (CODE_BITS)
    ) u_split (
        .word_i (rx_word),
        .code_o (fld_code),
        .mode_o (fld_mode)
    );

    assign load = frame_last & ~frame_n;

    dac_out_hold #(
        .CODE_BITS (CODE_BITS)
    ) u_hold (
        .rst_n  (rst_n),
        .sclk   (sclk),
        .load_i (load),
        .code_i (fld_code),
        .mode_i (fld_mode),
        .code_o (dac_code),
        .mode_o (mode_q)
    );

    dac_term_decode u_term (
        .mode_i (mode_q),
        .ctl_o  (term)
    );

    assign pwr_mode  = mode_q;
    assign amp_en    = term.amp_en;
    assign term_1k   = term.term_1k;
    assign term_100k = term.term_100k;
    assign out_hiz   = term.out_hiz;

endmodule

// File: rtl/dac_cmd_rx_chk.sv
module dac_cmd_rx_chk #(
    parameter int CODE_BITS = 16
) (
    input logic                 rst_n,
    input logic                 sclk,
    input logic                 frame_n,
    input logic [CODE_BITS-1:0] dac_code,
    input logic [1:0]           pwr_mode,
    input logic                 amp_en,
    input logic                 term_1k,
    input logic                 term_100k,
    input logic                 out_hiz,
    input logic                 frame_last,
    input logic                 frame_done
);

    always @(negedge sclk) begin
        if (!rst_n) begin
            AST_RESET_STATE: assert (dac_code == '0 && pwr_mode == 2'b00); // R1
        end
    end

    AST_TERM_ONE_HOT: assert property (@(negedge sclk) disable iff (!rst_n)
        $countones({amp_en, term_1k, term_100k, out_hiz}) == 1); // R4

    AST_FLOAT_MAP: assert property (@(negedge sclk) disable iff (!rst_n)
        (pwr_mode == 2'b11) |-> (out_hiz && !amp_en)); // R4

    AST_NO_EARLY_LOAD: assert property (@(negedge sclk) disable iff (!rst_n)
        !frame_last |=> ($stable(dac_code) && $stable(pwr_mode))); // R5

    AST_IDLE_HOLD: assert property (@(negedge sclk) disable iff (!rst_n)
        frame_n |=> ($stable(dac_code) && $stable(pwr_mode))); // R6

    AST_DONE_HOLD: assert property (@(negedge sclk) disable iff (!rst_n)
        frame_done |=> ($stable(dac_code) && $stable(pwr_mode))); // R7

endmodule

bind dac_cmd_rx dac_cmd_rx_chk #(.CODE_BITS(CODE_BITS)) u_chk (
    .rst_n      (rst_n),
    .sclk       (sclk),
    .frame_n    (frame_n),
    .dac_code   (dac_code),
    .pwr_mode   (pwr_mode),
    .amp_en     (amp_en),
    .term_1k    (term_1k),
    .term_100k  (term_100k),
    .out_hiz    (out_hiz),
    .frame_last (frame_last),
    .frame_done (frame_done)
);

// File: tb/sim_dac_cmd_rx.sv
module sim_dac_cmd_rx;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic frame_a = 1'b1, sdat_a = 1'b0;
    logic frame_b = 1'b1, sdat_b = 1'b0;

    logic [15:0] code_a;
    logic [1:0]  mode_a;
    logic        amp_a, t1k_a, t100k_a, hiz_a;
    logic [13:0] code_b;
    logic [1:0]  mode_b;
    logic        amp_b, t1k_b, t100k_b, hiz_b;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    logic [15:0] exp_code_a = '0;
    logic [1:0]  exp_mode_a = '0;
    logic [13:0] exp_code_b = '0;
    logic [1:0]  exp_mode_b = '0;

    always #2 clk = ~clk;

    dac_cmd_rx u0 (
        .rst_n (rst_n), .sclk (sclk), .frame_n (frame_a), .sdat (sdat_a),
        .dac_code (code_a), .pwr_mode (mode_a), .amp_en (amp_a),
        .term_1k (t1k_a), .term_100k (t100k_a), .out_hiz (hiz_a)
    );

    dac_cmd_rx #(.FRAME_BITS(16), .CODE_BITS(14)) u1 (
        .rst_n (rst_n), .sclk (sclk), .frame_n (frame_b), .sdat (sdat_b),
        .dac_code (code_b), .pwr_mode (mode_b), .amp_en (amp_b),
        .term_1k (t1k_b), .term_100k (t100k_b), .out_hiz (hiz_b)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] term_of(input logic [1:0] m);
        case (m)
            2'b00:   return 4'b1000;
            2'b01:   return 4'b0100;
            2'b10:   return 4'b0010;
            default: return 4'b0001;
        endcase
    endfunction

    task automatic check_a(input string req);
        chk({req, " code A"}, 32'(code_a), 32'(exp_code_a));
        chk({req, " mode A"}, 32'(mode_a), 32'(exp_mode_a));
        chk({req, " R4 term A"}, 32'({amp_a, t1k_a, t100k_a, hiz_a}), 32'(term_of(exp_mode_a)));
    endtask

    task automatic check_b(input string req);
        chk({req, " code B"}, 32'(code_b), 32'(exp_code_b));
        chk({req, " mode B"}, 32'(mode_b), 32'(exp_mode_b));
        chk({req, " R4 term B"}, 32'({amp_b, t1k_b, t100k_b, hiz_b}), 32'(term_of(exp_mode_b)));
    endtask

    task automatic set_frame(input bit side_b, input logic v);
        if (side_b) frame_b = v; else frame_a = v;
    endtask

    task automatic open_frame(input bit side_b);
        @(negedge clk) set_frame(side_b, 1'b1);
        repeat (4) @(negedge clk);
        set_frame(side_b, 1'b0);
        @(negedge clk);
    endtask

    task automatic close_frame(input bit side_b);
        @(negedge clk) set_frame(side_b, 1'b1);
        @(negedge clk);
    endtask

    // Sends bits w[total-1-first] down to w[total-first-count], one per falling sclk edge.
    task automatic drive(input bit side_b, input logic [23:0] w, input int total,
                         input int first, input int count);
        for (int i = 0; i < count; i++) begin
            @(negedge clk);
            if (side_b) sdat_b = w[total - 1 - first - i];
            else        sdat_a = w[total - 1 - first - i];
            @(posedge clk) sclk = 1'b0;
            @(posedge clk) sclk = 1'b1;
        end
        @(negedge clk);
    endtask

    initial begin
        logic [23:0] w;
        logic [15:0] c;
        logic [13:0] cb;
        logic [5:0]  junk;

        repeat (5) @(negedge clk);
        check_a("R1 reset");
        check_b("R1 reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R5 R8: sweep of modes, codes and ignored leading bits
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 20; k++) begin
                c = (k == 0) ? 16'h0000 : (k == 19) ? 16'hFFFF : 16'(k * 3277 + m * 911);
                junk = 6'(k * 7 + m * 3);
                w = {junk, 2'(m), c};
                open_frame(1'b0);
                drive(1'b0, w, 24, 0, 23);
                check_a("R5 before last edge");
                drive(1'b0, w, 24, 23, 1);
                exp_code_a = c;
                exp_mode_a = 2'(m);
                check_a("R2 R3 R8 load with frame low");
                close_frame(1'b0);
            end
        end

        // R6: abort at every bit position
        for (int k = 1; k < 24; k++) begin
            w = {6'h2A, 2'(k), 16'(k * 2749 + 5)};
            open_frame(1'b0);
            drive(1'b0, w, 24, 0, k);
            close_frame(1'b0);
            check_a("R6 aborted frame");
        end
        // R6: clock edges with frame high
        drive(1'b0, 24'hFFFFFF, 24, 0, 24);
        check_a("R6 idle edges");

        // R7: extra edges after execution
        w = {6'h00, 2'b01, 16'h5A3C};
        open_frame(1'b0);
        drive(1'b0, w, 24, 0, 24);
        exp_code_a = 16'h5A3C;
        exp_mode_a = 2'b01;
        check_a("R7 loaded");
        drive(1'b0, 24'hFFFFFF, 24, 0, 24);
        check_a("R7 extra edges ignored");
        close_frame(1'b0);
        w = {6'h3F, 2'b10, 16'h1234};
        open_frame(1'b0);
        drive(1'b0, w, 24, 0, 24);
        exp_code_a = 16'h1234;
        exp_mode_a = 2'b10;
        check_a("R7 next frame after reselect");
        close_frame(1'b0);

        // R9: short frame variant
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 16; k++) begin
                cb = (k == 15) ? 14'h3FFF : 14'(k * 1021 + m * 77);
                w = {8'h00, 2'(m), cb};
                open_frame(1'b1);
                drive(1'b1, w, 16, 0, 15);
                check_b("R9 before 16th edge");
                drive(1'b1, w, 16, 15, 1);
                exp_code_b = cb;
                exp_mode_b = 2'(m);
                check_b("R9 load on 16th edge");
                close_frame(1'b1);
            end
        end
        w = {8'h00, 2'b00, 14'h0AAA};
        open_frame(1'b1);
        drive(1'b1, w, 16, 0, 15);
        close_frame(1'b1);
        check_b("R9 R6 aborted short frame");
        check_a("R6 other instance untouched");

        // R1: asynchronous reset in the middle of a frame
        w = {6'h15, 2'b11, 16'hBEEF};
        open_frame(1'b0);
        drive(1'b0, w, 24, 0, 10);
        @(negedge clk) rst_n = 1'b0;
        #1;
        exp_code_a = '0;
        exp_mode_a = 2'b00;
        exp_code_b = '0;
        exp_mode_b = 2'b00;
        check_a("R1 async reset");
        check_b("R1 async reset");
        drive(1'b0, w, 24, 10, 2);
        @(negedge clk) rst_n = 1'b1;
        drive(1'b0, w, 24, 12, 12);
        check_a("R1 frame dropped by reset");
        close_frame(1'b0);
        open_frame(1'b0);
        drive(1'b0, w, 24, 0, 24);
        exp_code_a = 16'hBEEF;
        exp_mode_a = 2'b11;
        check_a("R2 R3 after reset");
        close_frame(1'b0);

        summary();
        $finish;
    end

endmodule